// File: doc/BRIEF.md
# Receive Reset Sequencer

This block runs the receive-side reset of one serial transceiver channel. Software or a higher-level controller holds a request line high and then releases it. On release, the block reads a 2-bit mode and two selection masks. One mask covers the physical-layer sub-blocks and the other covers the coding-layer sub-blocks. The block then drives a reset output into each selected sub-block, either one after another in a fixed order or all together. Each sub-block answers with a done level. Coding-layer work also needs a user-ready input, which tells the block that the user clock is stable.

The block has two completion flags. One reports that the physical-layer part has finished and the other reports that the whole sequence has finished. Any step that waits too long sets a sticky error flag, and the sequence then moves on. A second request line resets only the adaptation sub-block, on its own path. The mode and the masks play no part in that path.

Top module: `rx_reset_seq`

## Requirements
- R1: While `reset_req` is high, `all_done`, `phy_done` and every reset output of the main sequence are low from the next cycle on. A sequence starts on the first clock edge that sees `reset_req` low after it was high. A request during a running sequence aborts it, and the next release starts again from the first selected step.
- R2: With `mode` 2'b00, or with one of the two reserved codes 2'b01 and 2'b10, the selected steps run one at a time in this order: `phy_mask` bits 0,1,2,3,4,5,6, then `pcs_mask` bits 2,1,0,3. Unselected steps are skipped without a pulse. `phy_rst_out[i]` belongs to `phy_mask[i]` and `pcs_rst_out[j]` belongs to `pcs_mask[j]`.
- R3: With `mode` 2'b11, all selected reset outputs rise together in the same cycle.
- R4: Each reset pulse, from either the main sequence or the adaptation path, is high for exactly 8 clock cycles.
- R5: A step ends when its done input is high after its pulse. A coding-layer step also needs `user_ready` high, so `all_done` stays low while `user_ready` is low.
- R6: `phy_done` goes high once every selected physical-layer step has ended. In sequential mode it is already high when the first coding-layer pulse starts.
- R7: `all_done` rises only after every selected step has produced its pulse and ended. Until then it stays low.
- R8: If no step is selected (`phy_mask[6:0]` and `pcs_mask` all zero; `phy_mask[7]` is reserved and selects nothing), `all_done` and `phy_done` are high one cycle after the release.
- R9: If a done input (or `user_ready`) has not arrived 1024 cycles after a pulse ends, `timeout_err` is set and the step counts as ended. `timeout_err` stays high until the next sequence or adaptation start.
- R10: A high-then-low pulse on `adapt_req` gives one 8-cycle pulse on `phy_rst_out[4]` and on no other output. The mode and masks do not affect it, and `all_done` and `phy_done` keep their values.
- R11: After `rst_n` is released, every output is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| reset_req | input | 1 | Main reset request; the sequence starts on its release |
| mode | input | 2 | 2'b11 runs all steps at once; any other code runs them in sequence |
| phy_mask | input | 8 | Physical-layer step select; bit 7 reserved |
| pcs_mask | input | 4 | Coding-layer step select |
| user_ready | input | 1 | User clock stable |
| adapt_req | input | 1 | Adaptation-only reset request; acts on its release |
| phy_done_in | input | 7 | Done levels from the physical-layer sub-blocks |
| pcs_done_in | input | 4 | Done levels from the coding-layer sub-blocks |
| phy_rst_out | output | 7 | Physical-layer sub-block resets |
| pcs_rst_out | output | 4 | Coding-layer sub-block resets |
| phy_done | output | 1 | Physical-layer part complete |
| all_done | output | 1 | Whole sequence complete |
| timeout_err | output | 1 | Sticky wait-timeout flag |

## Verification
A wrong step index or a bad selection vector shows up at once as a reset output that rises out of order or for an unselected bit. The scoreboard catches this at the first rising edge. A wrong pulse counter shows as a pulse longer or shorter than eight cycles, and this is seen on the falling edge of that pulse. A broken completion condition shows as `all_done` rising while expected pulses are still pending, or staying low without `user_ready`. A broken timeout path shows about a thousand cycles after the stuck step, as a missing `timeout_err` or a run that never completes.

// File: rtl/rxrs_pkg.sv
package rxrs_pkg;
  typedef enum logic [1:0] {
    S_IDLE  = 2'd0,
    S_ARM   = 2'd1,
    S_PULSE = 2'd2,
    S_WAIT  = 2'd3
  } seq_state_t;

  typedef enum logic [1:0] {
    A_IDLE  = 2'd0,
    A_PULSE = 2'd1,
    A_WAIT  = 2'd2
  } adp_state_t;

  localparam logic [1:0] MODE_ALL_AT_ONCE = 2'b11;
endpackage

// File: rtl/rxrs_fall_det.sv
module rxrs_fall_det (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic fall
);
  logic din_q;

  always_ff @(posedge clk) begin
    if (!rst_n) din_q <= 1'b0;
    else        din_q <= din;
  end

  assign fall = din_q & ~din;
endmodule

// File: rtl/rxrs_adapt_path.sv
module rxrs_adapt_path #(
  parameter int PULSE_CYC   = 8,
  parameter int TIMEOUT_CYC = 1024
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic done_in,
  output logic rst_out,
  output logic err
);
  import rxrs_pkg::*;
  localparam int CW = $clog2(TIMEOUT_CYC + 1);

  adp_state_t     st;
  logic [CW-1:0]  cnt;
  logic           pulse_end;
  logic           wait_expired;

  assign pulse_end    = (st == A_PULSE) && (cnt == CW'(PULSE_CYC - 1));
  assign wait_expired = (st == A_WAIT) && (cnt == CW'(TIMEOUT_CYC - 1));
  assign rst_out      = (st == A_PULSE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st  <= A_IDLE;
      cnt <= '0;
      err <= 1'b0;
    end else if (start) begin
      st  <= A_PULSE;
      cnt <= '0;
      err <= 1'b0;
    end else begin
      unique case (st)
        A_PULSE: begin
          if (pulse_end) begin
            st  <= A_WAIT;
            cnt <= '0;
          end else cnt <= cnt + 1'b1;
        end
        A_WAIT: begin
          if (done_in || wait_expired) begin
            st  <= A_IDLE;
            cnt <= '0;
            if (!done_in) err <= 1'b1;
          end else cnt <= cnt + 1'b1;
        end
        default: cnt <= '0;
      endcase
    end
  end

  // R4: the pulse counter never runs past its length
  a_r4_adapt_pulse_len: assert property (@(posedge clk) disable iff (!rst_n)
    (st == A_PULSE) |-> (cnt < CW'(PULSE_CYC)));
  // R9: error stays set until the next adaptation start
  a_r9_adapt_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (err && !start) |=> err);
endmodule

// File: rtl/rxrs_main_fsm.sv
module rxrs_main_fsm #(
  parameter int NPHY        = 7,
  parameter int NPCS        = 4,
  parameter int PULSE_CYC   = 8,
  parameter int TIMEOUT_CYC = 1024
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   req_level,
  input  logic                   start,
  input  logic [1:0]             mode,
  input  logic [NPHY+NPCS-1:0]   sel_u,
  input  logic                   user_ready,
  input  logic [NPHY+NPCS-1:0]   done_u,
  output logic [NPHY+NPCS-1:0]   rst_u,
  output logic                   phy_done,
  output logic                   all_done,
  output logic                   err
);
  import rxrs_pkg::*;
  localparam int NSTEP = NPHY + NPCS;
  localparam int IW    = $clog2(NSTEP + 1);
  localparam int CW    = $clog2(TIMEOUT_CYC + 1);

  // step k in run order -> unified bit (phy bits first, then pcs bits)
  function automatic int step_to_bit(input int k);
    int j;
    if (k < NPHY) return k;
    j = k - NPHY;
    if (j < NPCS - 1) return NPHY + (NPCS - 2 - j);
    return NPHY + NPCS - 1;
  endfunction

  function automatic logic [NSTEP-1:0] to_order(input logic [NSTEP-1:0] u);
    logic [NSTEP-1:0] o;
    for (int k = 0; k < NSTEP; k++) o[k] = u[step_to_bit(k)];
    return o;
  endfunction

  function automatic logic [NSTEP-1:0] from_order(input logic [NSTEP-1:0] o);
    logic [NSTEP-1:0] u;
    for (int k = 0; k < NSTEP; k++) u[step_to_bit(k)] = o[k];
    return u;
  endfunction

  // first selected step at or after 'from'; NSTEP when none is left
  function automatic logic [IW-1:0] next_sel(input logic [NSTEP-1:0] s,
                                             input logic [IW-1:0]    from);
    logic [IW-1:0] r;
    r = IW'(NSTEP);
    for (int k = NSTEP - 1; k >= 0; k--)
      if (s[k] && (IW'(k) >= from)) r = IW'(k);
    return r;
  endfunction

  seq_state_t       st;
  logic [IW-1:0]    idx;
  logic [CW-1:0]    cnt;
  logic [NSTEP-1:0] sel;
  logic             single;

  logic [NSTEP-1:0] sel_new;
  logic [NSTEP-1:0] done_o;
  logic [NSTEP-1:0] rst_o;
  logic [IW-1:0]    first_new;
  logic [IW-1:0]    nxt_step;
  logic             pulse_end;
  logic             wait_expired;
  logic             step_ok;
  logic             grp_phy_ok;
  logic             grp_pcs_ok;
  logic             grp_all_ok;
  logic             pcs_any;

  assign sel_new      = to_order(sel_u);
  assign done_o       = to_order(done_u);
  assign first_new    = next_sel(sel_new, '0);
  assign nxt_step     = next_sel(sel, idx + 1'b1);
  assign pulse_end    = (st == S_PULSE) && (cnt == CW'(PULSE_CYC - 1));
  assign wait_expired = (st == S_WAIT) && (cnt == CW'(TIMEOUT_CYC - 1));
  assign pcs_any      = |sel[NSTEP-1:NPHY];
  assign step_ok      = done_o[idx] && ((idx < IW'(NPHY)) || user_ready);
  assign grp_phy_ok   = &(done_o[NPHY-1:0] | ~sel[NPHY-1:0]);
  assign grp_pcs_ok   = &(done_o[NSTEP-1:NPHY] | ~sel[NSTEP-1:NPHY])
                        && (user_ready || !pcs_any);
  assign grp_all_ok   = grp_phy_ok && grp_pcs_ok;

  generate
    for (genvar k = 0; k < NSTEP; k++) begin : g_rst
      assign rst_o[k] = (st == S_PULSE) &&
                        (single ? sel[k] : (idx == IW'(k)));
    end
  endgenerate
  assign rst_u = from_order(rst_o);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      idx      <= '0;
      cnt      <= '0;
      sel      <= '0;
      single   <= 1'b0;
      phy_done <= 1'b0;
      all_done <= 1'b0;
      err      <= 1'b0;
    end else if (req_level) begin
      st       <= S_ARM;
      cnt      <= '0;
      phy_done <= 1'b0;
      all_done <= 1'b0;
    end else if (start) begin
      err    <= 1'b0;
      cnt    <= '0;
      sel    <= sel_new;
      single <= (mode == MODE_ALL_AT_ONCE);
      idx    <= first_new;
      if (sel_new == '0) begin
        st       <= S_IDLE;
        phy_done <= 1'b1;
        all_done <= 1'b1;
      end else begin
        st       <= S_PULSE;
        phy_done <= (sel_new[NPHY-1:0] == '0);
      end
    end else begin
      unique case (st)
        S_PULSE: begin
          if (pulse_end) begin
            st  <= S_WAIT;
            cnt <= '0;
          end else cnt <= cnt + 1'b1;
        end
        S_WAIT: begin
          if (single) begin
            if (grp_phy_ok) phy_done <= 1'b1;
            if (grp_all_ok || wait_expired) begin
              phy_done <= 1'b1;
              all_done <= 1'b1;
              if (!grp_all_ok) err <= 1'b1;
              st  <= S_IDLE;
              cnt <= '0;
            end else cnt <= cnt + 1'b1;
          end else begin
            if (step_ok || wait_expired) begin
              if (!step_ok) err <= 1'b1;
              cnt <= '0;
              if (nxt_step >= IW'(NPHY)) phy_done <= 1'b1;
              if (nxt_step == IW'(NSTEP)) begin
                all_done <= 1'b1;
                st       <= S_IDLE;
              end else begin
                idx <= nxt_step;
                st  <= S_PULSE;
              end
            end else cnt <= cnt + 1'b1;
          end
        end
        default: cnt <= '0;
      endcase
    end
  end

  // R1: a held request silences the sequence and both done flags
  a_r1_req_clears: assert property (@(posedge clk) disable iff (!rst_n)
    req_level |=> (rst_u == '0) && !all_done && !phy_done);
  // R2: sequential mode drives at most one reset at a time
  a_r2_seq_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    !single |-> $onehot0(rst_u));
  // R4: pulse counter stays inside the pulse length
  a_r4_pulse_len: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_PULSE) |-> (cnt < CW'(PULSE_CYC)));
  // R5: completion with coding-layer steps and no error needs user_ready
  a_r5_ready_gate: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(all_done) && pcs_any && !err && (sel != '0)) |-> $past(user_ready));
  // R6: physical-layer part done before a coding-layer pulse in sequence
  a_r6_phy_first: assert property (@(posedge clk) disable iff (!rst_n)
    (!single && (|rst_u[NSTEP-1:NPHY])) |-> phy_done);
  // R7: no pulse is active while all_done is reported
  a_r7_quiet_when_done: assert property (@(posedge clk) disable iff (!rst_n)
    all_done |-> (rst_u == '0));
  // R9: error is sticky until a new start
  a_r9_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (err && !start) |=> err);
endmodule

// File: rtl/rx_reset_seq.sv
module rx_reset_seq #(
  parameter int PHY_W       = 8,
  parameter int PCS_W       = 4,
  parameter int PULSE_CYC   = 8,
  parameter int TIMEOUT_CYC = 1024,
  parameter int ADAPT_BIT   = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               reset_req,
  input  logic [1:0]         mode,
  input  logic [PHY_W-1:0]   phy_mask,
  input  logic [PCS_W-1:0]   pcs_mask,
  input  logic               user_ready,
  input  logic               adapt_req,
  input  logic [PHY_W-2:0]   phy_done_in,
  input  logic [PCS_W-1:0]   pcs_done_in,
  output logic [PHY_W-2:0]   phy_rst_out,
  output logic [PCS_W-1:0]   pcs_rst_out,
  output logic               phy_done,
  output logic               all_done,
  output logic               timeout_err
);
  localparam int NPHY  = PHY_W - 1;
  localparam int NSTEP = NPHY + PCS_W;

  logic             start_evt;
  logic             adapt_evt;
  logic [NSTEP-1:0] main_rst_u;
  logic             adapt_rst;
  logic             main_err;
  logic             adapt_err;
  logic             unused_rsvd_mask;

  assign unused_rsvd_mask = phy_mask[PHY_W-1];

  rxrs_fall_det u_req_edge (
    .clk(clk), .rst_n(rst_n), .din(reset_req), .fall(start_evt)
  );
  rxrs_fall_det u_adapt_edge (
    .clk(clk), .rst_n(rst_n), .din(adapt_req), .fall(adapt_evt)
  );

  rxrs_main_fsm #(
    .NPHY(NPHY), .NPCS(PCS_W), .PULSE_CYC(PULSE_CYC), .TIMEOUT_CYC(TIMEOUT_CYC)
  ) u_main (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_level (reset_req),
    .start     (start_evt),
    .mode      (mode),
    .sel_u     ({pcs_mask, phy_mask[NPHY-1:0]}),
    .user_ready(user_ready),
    .done_u    ({pcs_done_in, phy_done_in}),
    .rst_u     (main_rst_u),
    .phy_done  (phy_done),
    .all_done  (all_done),
    .err       (main_err)
  );

  rxrs_adapt_path #(
    .PULSE_CYC(PULSE_CYC), .TIMEOUT_CYC(TIMEOUT_CYC)
  ) u_adapt (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (adapt_evt),
    .done_in(phy_done_in[ADAPT_BIT]),
    .rst_out(adapt_rst),
    .err    (adapt_err)
  );

  generate
    for (genvar i = 0; i < NPHY; i++) begin : g_phy_out
      if (i == ADAPT_BIT) begin : g_adapt
        assign phy_rst_out[i] = main_rst_u[i] | adapt_rst;
      end else begin : g_plain
        assign phy_rst_out[i] = main_rst_u[i];
      end
    end
  endgenerate
  assign pcs_rst_out = main_rst_u[NSTEP-1:NPHY];
  assign timeout_err = main_err | adapt_err;

  // R10: the adaptation path never drives any other reset output
  a_r10_adapt_only_bit: assert property (@(posedge clk) disable iff (!rst_n)
    adapt_rst |-> (phy_rst_out[ADAPT_BIT] && (pcs_rst_out == main_rst_u[NSTEP-1:NPHY])));
endmodule

// File: tb/rx_reset_seq_tb.sv
module rx_reset_seq_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NB = 11;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reset_req = 1'b0;
  logic [1:0]  mode = 2'b00;
  logic [7:0]  phy_mask = 8'h00;
  logic [3:0]  pcs_mask = 4'h0;
  logic        user_ready = 1'b1;
  logic        adapt_req = 1'b0;
  logic [6:0]  phy_done_in;
  logic [3:0]  pcs_done_in;
  logic [6:0]  phy_rst_out;
  logic [3:0]  pcs_rst_out;
  logic        phy_done, all_done, timeout_err;

  int total = 0;
  int bad = 0;

  logic [NB-1:0] exp_q[$];
  logic [NB-1:0] stuck = '0;
  logic          abort_tb = 1'b0;
  logic          seq_tb = 1'b0;
  logic [NB-1:0] sub_done = '0;
  int            sub_cnt[NB];

  always #(CLK_PERIOD/2) clk = ~clk;

  rx_reset_seq u_dut (
    .clk(clk), .rst_n(rst_n), .reset_req(reset_req), .mode(mode),
    .phy_mask(phy_mask), .pcs_mask(pcs_mask), .user_ready(user_ready),
    .adapt_req(adapt_req), .phy_done_in(phy_done_in), .pcs_done_in(pcs_done_in),
    .phy_rst_out(phy_rst_out), .pcs_rst_out(pcs_rst_out),
    .phy_done(phy_done), .all_done(all_done), .timeout_err(timeout_err)
  );

  logic [NB-1:0] rst_all;
  assign rst_all     = {pcs_rst_out, phy_rst_out};
  assign phy_done_in = sub_done[6:0];
  assign pcs_done_in = sub_done[10:7];

  // sub-block model: done drops during reset, rises a few cycles after
  always @(posedge clk) begin
    for (int i = 0; i < NB; i++) begin
      if (!rst_n || rst_all[i]) begin
        sub_done[i] <= 1'b0;
        sub_cnt[i]  <= 0;
      end else if (!sub_done[i] && !stuck[i]) begin
        if (sub_cnt[i] >= 2 + (i % 3)) sub_done[i] <= 1'b1;
        else sub_cnt[i] <= sub_cnt[i] + 1;
      end
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, expv);
    end
  endtask

  // monitor: pops expected reset vectors and checks pulse lengths
  logic [NB-1:0] prev_rst = '0;
  int plen[NB];
  always @(negedge clk) begin
    logic [NB-1:0] rising;
    rising = rst_all & ~prev_rst;
    if (rising != '0) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R2", "unexpected reset rise", int'(rising), 0);
      end else begin
        logic [NB-1:0] e;
        e = exp_q.pop_front();
        check(rising == e, "R2/R3", "reset rise pattern", int'(rising), int'(e));
      end
      if (seq_tb && (|rising[10:7]))
        check(phy_done, "R6", "phy_done at first coding pulse", int'(phy_done), 1);
    end
    for (int i = 0; i < NB; i++) begin
      if (rst_all[i]) plen[i] = plen[i] + 1;
      else begin
        if (prev_rst[i] && !abort_tb)
          check(plen[i] == 8, "R4", "pulse length", plen[i], 8);
        plen[i] = 0;
      end
    end
    prev_rst = rst_all;
  end

  task automatic tick();
    @(negedge clk); #1;
  endtask

  function automatic int order_bit(input int k);
    int ord[NB] = '{0, 1, 2, 3, 4, 5, 6, 9, 8, 7, 10};
    return ord[k];
  endfunction

  task automatic push_expect(input logic [1:0] m, input logic [7:0] pm, input logic [3:0] cm);
    logic [NB-1:0] s;
    s = {cm, pm[6:0]};
    if (m == 2'b11) begin
      if (s != '0) exp_q.push_back(s);
    end else begin
      for (int k = 0; k < NB; k++)
        if (s[order_bit(k)]) exp_q.push_back(NB'(1) << order_bit(k));
    end
  endtask

  task automatic request(input logic [1:0] m, input logic [7:0] pm, input logic [3:0] cm);
    tick();
    mode = m; phy_mask = pm; pcs_mask = cm; reset_req = 1'b1;
    seq_tb = (m != 2'b11);
    tick(); tick();
    check(!all_done && !phy_done, "R1", "done flags low under request",
          int'({all_done, phy_done}), 0);
    push_expect(m, pm, cm);
    reset_req = 1'b0;
  endtask

  task automatic wait_done(input int limit, input string req);
    int n = 0;
    while (!all_done && n < limit) begin tick(); n++; end
    check(all_done, req, "all_done reached", int'(all_done), 1);
    check(exp_q.size() == 0, "R7", "pending pulses at completion", exp_q.size(), 0);
    check(phy_done, "R6", "phy_done at completion", int'(phy_done), 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) tick();
    rst_n = 1'b1;
    tick();
    check({phy_rst_out, pcs_rst_out, phy_done, all_done, timeout_err} == '0,
          "R11", "outputs after reset", int'({phy_rst_out, pcs_rst_out}), 0);

    // R2: full sequential run
    request(2'b00, 8'h7F, 4'hF);
    wait_done(3000, "R2");

    // R3: all at once, mixed masks
    request(2'b11, 8'h25, 4'h6);
    wait_done(3000, "R3");

    // R2: reserved codes behave as sequential
    request(2'b01, 8'h0A, 4'h9);
    wait_done(3000, "R2");
    request(2'b10, 8'h41, 4'h4);
    wait_done(3000, "R2");

    // R8: nothing selected, reserved bit alone selects nothing
    request(2'b00, 8'h80, 4'h0);
    tick();
    check(all_done && phy_done, "R8", "done one cycle after release",
          int'({all_done, phy_done}), 3);
    request(2'b11, 8'h00, 4'h0);
    tick();
    check(all_done && phy_done, "R8", "single mode empty masks",
          int'({all_done, phy_done}), 3);

    // R5: coding step waits for user_ready
    user_ready = 1'b0;
    request(2'b00, 8'h01, 4'h1);
    repeat (60) tick();
    check(!all_done, "R5", "all_done held without user_ready", int'(all_done), 0);
    check(phy_done, "R6", "phy part done while waiting", int'(phy_done), 1);
    check(exp_q.size() == 0, "R5", "both pulses seen", exp_q.size(), 0);
    user_ready = 1'b1;
    tick();
    check(all_done, "R5", "all_done after user_ready", int'(all_done), 1);

    // R1: restart mid-sequence
    request(2'b00, 8'h7F, 4'h0);
    repeat (30) tick();
    abort_tb = 1'b1;
    reset_req = 1'b1;
    tick();
    check(rst_all == '0, "R1", "resets drop on new request", int'(rst_all), 0);
    exp_q.delete();
    tick();
    push_expect(2'b00, 8'h7F, 4'h0);
    reset_req = 1'b0;
    tick();
    abort_tb = 1'b0;
    wait_done(3000, "R1");

    // R9: timeout on a stuck step
    stuck = NB'(1) << 2;
    request(2'b00, 8'h07, 4'h0);
    wait_done(3000, "R9");
    check(timeout_err, "R9", "timeout flag set", int'(timeout_err), 1);
    stuck = '0;
    repeat (20) tick();
    check(timeout_err, "R9", "timeout flag sticky", int'(timeout_err), 1);
    request(2'b00, 8'h01, 4'h0);
    tick();
    check(!timeout_err, "R9", "flag cleared by new start", int'(timeout_err), 0);
    wait_done(3000, "R9");

    // R10: adaptation-only reset ignores mode and masks
    tick();
    mode = 2'b00; phy_mask = 8'h7F; pcs_mask = 4'hF;
    adapt_req = 1'b1;
    tick(); tick();
    exp_q.push_back(NB'(1) << 4);
    adapt_req = 1'b0;
    repeat (30) tick();
    check(exp_q.size() == 0, "R10", "single adapt pulse seen", exp_q.size(), 0);
    check(all_done && phy_done, "R10", "done flags untouched",
          int'({all_done, phy_done}), 3);
    check(!timeout_err, "R10", "no adapt error", int'(timeout_err), 0);

    repeat (5) tick();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule